// File: doc/BRIEF.md
# Dataset Staging and Smoothing Sequencer

This controller runs a fixed dataset through a smoothing unit. After a start request it samples a display-mode switch once. It then copies every entry of a read-only table into a working RAM, one entry per cycle. Next it reads each entry back from the RAM and hands it to an external smoothing unit over a valid/done handshake. When the last entry has been processed, it parks in one of two display states.

The outputs are Mealy-type. The RAM write data follows the table word in the same cycle, and the sample handed to the smoothing unit follows the RAM read port in the same cycle. The display word shows either the smoothed result of the last entry or the result of a chosen middle entry. The table contents, the RAM array, the arithmetic and the segment encoding all live outside the block.

Top module: `stage_smooth_seq`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after reset, state_code is 0 (idle), ram_we, ram_re, smooth_valid and wr_done are low, and disp_word is 0.
- R2: The state codes are 0 idle, 1 mode pick, 2 staging, 3 smoothing, 4 show final and 5 show middle. A high start moves idle to code 1 at the next edge, and code 1 always moves to code 2 at the next edge. In any other state, start has no effect.
- R3: Staging lasts exactly NUM_DATA cycles. In cycle i, ram_we is 1, rom_addr and ram_addr are both i, and ram_wdata equals the low OUT_W bits of rom_data in that same cycle.
- R4: wr_done is high only in the staging cycle that writes address NUM_DATA-1. The next cycle is the first smoothing cycle.
- R5: Each read-back begins with one cycle where ram_re is 1 and ram_addr is i. In the following cycle, smooth_valid is 1, ram_addr is still i, and smooth_data equals ram_rdata in that cycle. ram_we stays low throughout smoothing.
- R6: After smooth_valid, the controller waits with both strobes low until smooth_done is seen. Only then does it issue the read of i+1, in the next cycle. A smooth_done that arrives in any other cycle (idle, staging, the read cycle or the valid cycle) has no effect.
- R7: The mode_sw value present in the mode-pick cycle decides the ending state: 0 selects show final (code 4) and 1 selects show middle (code 5). Changes to mode_sw after that cycle are ignored.
- R8: In code 4, disp_word equals the smooth_result accepted with the done for entry NUM_DATA-1. In code 5, it equals the smooth_result accepted with the done for entry MID_IDX (default NUM_DATA/2). In all other states, disp_word is 0.
- R9: Both display states hold their state code and disp_word until reset, whatever start, mode_sw and smooth_done do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Run request, honoured in idle only |
| mode_sw | input | 1 | Display choice, sampled in the mode-pick state |
| rom_data | input | IN_W | Table word at rom_addr (combinational) |
| ram_rdata | input | OUT_W | RAM read data, one cycle after ram_re |
| smooth_done | input | 1 | Smoothing unit finished the current sample |
| smooth_result | input | OUT_W | Smoothed value, valid with smooth_done |
| rom_addr | output | ADDR_W | Table address |
| ram_addr | output | ADDR_W | RAM address for write and read |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | OUT_W | RAM write data |
| ram_re | output | 1 | RAM read strobe |
| smooth_valid | output | 1 | Sample presented to the smoothing unit |
| smooth_data | output | OUT_W | Sample value |
| wr_done | output | 1 | Last staging write in progress |
| state_code | output | 3 | Current state code |
| disp_word | output | OUT_W | Selected result for display |

## Verification
The in-RTL assertions check the step-by-one staging addresses, the single wr_done cycle and its hand-over to the first read of address 0, the valid cycle that follows every read, the absence of a read while waiting for done, idle holding without start, reset, and the frozen display states. Only the bench scenarios can show the rest. That covers correct data moving from the table through the RAM into the smoothing unit, stray done pulses being ignored, the mode latched in the pick cycle winning over later switch changes, and the right final or middle result reaching the display. The bench also covers a reset that arrives in the middle of the smoothing pass.

// File: rtl/stage_seq_pkg.sv
package stage_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_PICK       = 3'd1,
    ST_STAGE      = 3'd2,
    ST_SMOOTH     = 3'd3,
    ST_SHOW_FINAL = 3'd4,
    ST_SHOW_MID   = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_READ  = 2'd0,
    PH_VALID = 2'd1,
    PH_WAIT  = 2'd2
  } rd_phase_e;

  // Read-back sub-phase sequence; a done only counts while waiting.
  function automatic rd_phase_e phase_after(input rd_phase_e ph, input logic done);
    case (ph)
      PH_READ:  return PH_VALID;
      PH_VALID: return PH_WAIT;
      default:  return done ? PH_READ : PH_WAIT;
    endcase
  endfunction

endpackage

// File: rtl/seq_addr_ctr.sv
module seq_addr_ctr #(
  parameter int W     = 10,
  parameter int COUNT = 1024
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         at_last
);
  localparam logic [W-1:0] LAST = W'(COUNT - 1);

  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return (v == LAST) ? '0 : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (clr)      cnt <= '0;
    else if (inc) cnt <= bump(cnt);
  end

  assign at_last = (cnt == LAST);
endmodule

// File: rtl/seq_hold_reg.sv
module seq_hold_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/stage_smooth_seq.sv
module stage_smooth_seq
  import stage_seq_pkg::*;
#(
  parameter int NUM_DATA = 1024,
  parameter int ADDR_W   = 10,
  parameter int IN_W     = 64,
  parameter int OUT_W    = 32,
  parameter int MID_IDX  = NUM_DATA / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_sw,
  input  logic [IN_W-1:0]   rom_data,
  input  logic [OUT_W-1:0]  ram_rdata,
  input  logic              smooth_done,
  input  logic [OUT_W-1:0]  smooth_result,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic [OUT_W-1:0]  ram_wdata,
  output logic              ram_re,
  output logic              smooth_valid,
  output logic [OUT_W-1:0]  smooth_data,
  output logic              wr_done,
  output logic [2:0]        state_code,
  output logic [OUT_W-1:0]  disp_word
);
  localparam logic [ADDR_W-1:0] MID_A = ADDR_W'(MID_IDX);

  seq_state_e st_q, st_d;
  rd_phase_e  ph_q;
  logic       mode_q;

  logic [ADDR_W-1:0] w_idx, r_idx;
  logic              w_last, r_last;
  logic [OUT_W-1:0]  fin_q, mid_q;

  // Named internal events
  logic write_evt, read_evt, valid_evt, done_take, last_take, mid_take, pick_evt;
  assign write_evt = (st_q == ST_STAGE);
  assign read_evt  = (st_q == ST_SMOOTH) && (ph_q == PH_READ);
  assign valid_evt = (st_q == ST_SMOOTH) && (ph_q == PH_VALID);
  assign done_take = (st_q == ST_SMOOTH) && (ph_q == PH_WAIT) && smooth_done;
  assign last_take = done_take && r_last;
  assign mid_take  = done_take && (r_idx == MID_A);
  assign pick_evt  = (st_q == ST_PICK);

  generate
    if (IN_W > OUT_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^rom_data[IN_W-1:OUT_W];
    end
  endgenerate

  seq_addr_ctr #(.W(ADDR_W), .COUNT(NUM_DATA)) u_wctr (
    .clk(clk), .clr(rst || pick_evt), .inc(write_evt), .cnt(w_idx), .at_last(w_last)
  );
  seq_addr_ctr #(.W(ADDR_W), .COUNT(NUM_DATA)) u_rctr (
    .clk(clk), .clr(rst || pick_evt), .inc(done_take && !r_last), .cnt(r_idx), .at_last(r_last)
  );
  seq_hold_reg #(.W(OUT_W)) u_fin (
    .clk(clk), .rst(rst), .load(last_take), .d(smooth_result), .q(fin_q)
  );
  seq_hold_reg #(.W(OUT_W)) u_mid (
    .clk(clk), .rst(rst), .load(mid_take), .d(smooth_result), .q(mid_q)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (start) st_d = ST_PICK;
      ST_PICK:   st_d = ST_STAGE;
      ST_STAGE:  if (w_last) st_d = ST_SMOOTH;
      ST_SMOOTH: if (last_take) st_d = mode_q ? ST_SHOW_MID : ST_SHOW_FINAL;
      default:   st_d = st_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_READ;
      mode_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ph_q <= (st_q == ST_SMOOTH) ? phase_after(ph_q, smooth_done) : PH_READ;
      if (pick_evt) mode_q <= mode_sw;
    end
  end

  assign rom_addr     = w_idx;
  assign ram_addr     = (st_q == ST_SMOOTH) ? r_idx : w_idx;
  assign ram_we       = write_evt;
  assign ram_wdata    = rom_data[OUT_W-1:0];
  assign ram_re       = read_evt;
  assign smooth_valid = valid_evt;
  assign smooth_data  = ram_rdata;
  assign wr_done      = write_evt && w_last;
  assign state_code   = st_q;
  assign disp_word    = (st_q == ST_SHOW_FINAL) ? fin_q :
                        (st_q == ST_SHOW_MID)   ? mid_q : '0;

  // Assertions
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (state_code == 3'd0 && !ram_we && !ram_re && !smooth_valid && disp_word == '0)); // R1
  AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (rst) (state_code == 3'd0 && !start) |=> state_code == 3'd0); // R2
  AST_WRITE_STEP: assert property (@(posedge clk) disable iff (rst) (ram_we && !wr_done) |=> (ram_we && ram_addr == $past(ram_addr) + 1'b1)); // R3
  AST_LAST_WRITE: assert property (@(posedge clk) disable iff (rst) wr_done |=> (state_code == 3'd3 && ram_re && ram_addr == '0)); // R4
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst) ram_re |=> (smooth_valid && ram_addr == $past(ram_addr))); // R5
  AST_WAIT_NO_READ: assert property (@(posedge clk) disable iff (rst) smooth_valid |=> (!ram_re && !ram_we)); // R6
  AST_SHOW_HOLDS: assert property (@(posedge clk) disable iff (rst) (state_code == 3'd4 || state_code == 3'd5) |=> ($stable(state_code) && $stable(disp_word))); // R9
endmodule

// File: tb/stage_smooth_seq_bench.sv
module stage_smooth_seq_bench;
  localparam int N   = 16;
  localparam int AW  = 4;
  localparam int MID = N / 2;
  localparam int CLKP = 20;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, mode_sw = 1'b0;
  logic smooth_done = 1'b0;
  logic [31:0] smooth_result = '0;
  logic [63:0] rom_data;
  logic [31:0] ram_rdata = '0;
  logic [AW-1:0] rom_addr, ram_addr;
  logic ram_we, ram_re, smooth_valid, wr_done;
  logic [31:0] ram_wdata, smooth_data, disp_word;
  logic [2:0] state_code;

  always #(CLKP/2) clk = ~clk;

  stage_smooth_seq #(.NUM_DATA(N), .ADDR_W(AW), .IN_W(64), .OUT_W(32)) u_stage_smooth_seq (
    .clk(clk), .rst(rst), .start(start), .mode_sw(mode_sw), .rom_data(rom_data),
    .ram_rdata(ram_rdata), .smooth_done(smooth_done), .smooth_result(smooth_result),
    .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .ram_re(ram_re), .smooth_valid(smooth_valid), .smooth_data(smooth_data),
    .wr_done(wr_done), .state_code(state_code), .disp_word(disp_word));

  function automatic logic [63:0] rom_fn(input int a);
    return {32'hC0DE0000 | 32'(a), 32'h3F000000 + 32'(a) * 32'h00011111};
  endfunction
  assign rom_data = rom_fn(int'(rom_addr));

  // Environment RAM: one cycle read latency
  logic [31:0] mem [N];
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  int checks = 0, errors = 0, cyc = 0;
  // Reference model state
  int m_st = 0, m_w = 0, m_r = 0, m_ph = 0;
  bit m_mode = 0;
  logic [31:0] m_fin = '0, m_mid = '0;
  // Smoothing unit model
  int cd = 0, vcount = 0, ep = 1;
  bit stray_en = 0;
  logic [31:0] pend = '0;
  logic [31:0] res_log [N];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    if (cd > 0) begin
      cd--;
      if (cd == 0) begin
        smooth_done = 1'b1;
        smooth_result = pend + 32'h01010101 * 32'(ep);
      end else smooth_done = 1'b0;
    end else begin
      smooth_done = stray_en && (cyc % 4 == 1) && !(m_st == 3 && m_ph == 2);
      smooth_result = 32'hDEAD0000 | 32'(cyc);
    end
    #1;
    // Compare outputs against model
    chk("R2 state code", {29'd0, state_code}, 32'(m_st));
    chk("R3 write strobe", {31'd0, ram_we}, {31'd0, m_st == 2});
    chk("R5 read strobe", {31'd0, ram_re}, {31'd0, m_st == 3 && m_ph == 0});
    chk("R5 valid strobe", {31'd0, smooth_valid}, {31'd0, m_st == 3 && m_ph == 1});
    chk("R4 write complete", {31'd0, wr_done}, {31'd0, m_st == 2 && m_w == N - 1});
    if (m_st == 2) begin
      chk("R3 table address", 32'(rom_addr), 32'(m_w));
      chk("R3 ram address", 32'(ram_addr), 32'(m_w));
      chk("R3 write data", ram_wdata, rom_fn(m_w) >> 0);
    end
    if (m_st == 3) chk("R6 read address", 32'(ram_addr), 32'(m_r));
    if (m_st == 3 && m_ph == 1) chk("R5 sample data", smooth_data, rom_fn(m_r) >> 0);
    chk("R8 display word", disp_word, m_st == 4 ? m_fin : (m_st == 5 ? m_mid : 32'h0));
    // Smoothing unit reacts to the valid sample
    if (smooth_valid) begin
      pend = smooth_data;
      cd = 1 + (vcount % 3);
      vcount++;
    end
    if (smooth_done && m_st == 3 && m_ph == 2) res_log[m_r] = smooth_result;
    // Model next state
    if (rst) begin
      m_st = 0; m_w = 0; m_r = 0; m_ph = 0; m_mode = 0; m_fin = '0; m_mid = '0; cd = 0;
    end else begin
      case (m_st)
        0: if (start) m_st = 1;
        1: begin m_mode = mode_sw; m_w = 0; m_r = 0; m_ph = 0; m_st = 2; end
        2: if (m_w == N - 1) begin m_w = 0; m_st = 3; end else m_w++;
        3: begin
          if (m_ph == 0) m_ph = 1;
          else if (m_ph == 1) m_ph = 2;
          else if (smooth_done) begin
            if (m_r == MID) m_mid = smooth_result;
            if (m_r == N - 1) begin m_fin = smooth_result; m_st = m_mode ? 5 : 4; end
            else begin m_r++; m_ph = 0; end
          end
        end
        default: ;
      endcase
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic run_to_show(input bit flip);
    for (int k = 0; k < 4 * N * 6 && m_st != 4 && m_st != 5; k++) begin
      if (m_st == 2 && m_w == 3) mode_sw = flip;
      start = (k % 7 == 3);
      step();
    end
    start = 1'b0;
  endtask

  initial begin
    #(CLKP * 20000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d actual running expected finished", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) step();
    rst = 1'b0;
    chk("R1 reset state", {29'd0, state_code}, 32'd0);
    chk("R1 reset strobes", {29'd0, ram_we, ram_re, smooth_valid}, 32'd0);
    // Idle with stray done pulses, no start
    stray_en = 1;
    for (int i = 0; i < 4; i++) step();
    chk("R2 idle without start", {29'd0, state_code}, 32'd0);
    // Episode 1: final result, switch flipped after pick
    ep = 1; mode_sw = 1'b0; start = 1'b1; step(); start = 1'b0;
    chk("R2 pick state", {29'd0, state_code}, 32'd1);
    run_to_show(1'b1);
    chk("R7 final shown despite switch flip", {29'd0, state_code}, 32'd4);
    chk("R8 final result", disp_word, res_log[N - 1]);
    for (int i = 0; i < 6; i++) begin start = i[0]; mode_sw = ~i[0]; step(); end
    start = 1'b0;
    chk("R9 final holds", disp_word, res_log[N - 1]);
    // Episode 2: middle result
    rst = 1'b1; step(); step(); rst = 1'b0;
    chk("R1 display cleared", disp_word, 32'd0);
    ep = 2; mode_sw = 1'b1; start = 1'b1; step(); start = 1'b0;
    run_to_show(1'b0);
    chk("R7 middle shown", {29'd0, state_code}, 32'd5);
    chk("R8 middle result", disp_word, res_log[MID]);
    for (int i = 0; i < 5; i++) begin start = 1'b1; step(); end
    start = 1'b0;
    chk("R9 middle holds", {29'd0, state_code}, 32'd5);
    // Episode 3: reset during smoothing
    rst = 1'b1; step(); rst = 1'b0;
    ep = 3; mode_sw = 1'b0; start = 1'b1; step(); start = 1'b0;
    for (int i = 0; i < N + 12; i++) step();
    chk("R6 mid-run in smoothing", {29'd0, state_code}, 32'd3);
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1 reset from smoothing", {29'd0, state_code}, 32'd0);
    chk("R1 strobes after reset", {28'd0, ram_we, ram_re, smooth_valid, wr_done}, 32'd0);
    for (int i = 0; i < 3; i++) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule